// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is a programmable controller that takes the place of fixed next-state logic. A 12-bit sequence address register selects one 32-bit micro-word from a writable control store on every clock cycle. The upper half of the word is sent to an external datapath as its command. The lower half tells the sequencer how to pick the next address.

The next address can be the current one plus one, an absolute target, or a target taken only when a chosen datapath status flag is set or clear. A subroutine call saves the return address on a four-entry stack, and a return restores it. A global exception input overrides all of these and forces a fixed handler address. The store is loaded through a simple write port while the sequencer is held in reset. After reset is released, the program starts at address 0.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high, the address output is 0 after the next clock edge. At the first edge after `rst` falls, the sequencer fetches from address 0, and `cmd_o` shows bits [31:16] of word 0.
- R2: Each micro-word is split into fields as follows. Bits [31:16] are the command and appear on `cmd_o` while the word is current. Bits [15:12] are the next-operation code. Bits [11:0] are the target address. Bits [31:30] select which of the four `status_i` bits is the test flag.
- R3: Operation code 0 (increment) moves the address to the current address + 1, and the target field is ignored. Any code from 6 to 15 behaves the same way.
- R4: Operation code 1 (absolute jump) loads the target field into the address register.
- R5: Operation code 2 jumps to the target when the selected flag is 1 and increments otherwise. Operation code 3 jumps to the target when the selected flag is 0 and increments otherwise. The flag is sampled in the same cycle the word is current.
- R6: Operation code 4 (call) saves the current address + 1 on the return stack and jumps to the target. Operation code 5 (return) loads the most recently saved address and removes it from the stack.
- R7: The return stack holds 4 entries. A fifth call without a return drops the oldest saved address. A return with the stack empty goes to address 0.
- R8: When `exc_i` is high, the next address is the handler vector 0xF00, whatever the current operation is. A call or return taken under an exception leaves the stack unchanged.
- R9: Store writes are carried out only while `rst` is high. A write requested while the sequencer runs does not change the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables store loading |
| wr_en_i | input | 1 | Control store write enable |
| wr_addr_i | input | 12 | Control store write address |
| wr_data_i | input | 32 | Control store write data |
| status_i | input | 4 | Datapath status flags |
| exc_i | input | 1 | Global exception request |
| addr_o | output | 12 | Current sequence address |
| cmd_o | output | 16 | Datapath command of the current micro-word |

## Verification
A wrong next-address decision shows on `addr_o` one clock edge after the offending word was current. From then on `cmd_o` also carries the command of the wrong word. Corruption of the return stack stays hidden until a return is executed, so the call tests nest, overflow and underflow the stack and then unwind it. Each return target is checked at the edge where the return executes. Store writes attempted while running, and exceptions taken on a call, are each followed by fetches whose command or return target would reveal a changed store or a pushed entry.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W   = 12;
  localparam int WORD_W   = 32;
  localparam int CMD_W    = 16;
  localparam int OP_W     = 4;
  localparam int FLAG_N   = 4;
  localparam int STK_N    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_INC  = 4'd0,
    OP_JMP  = 4'd1,
    OP_JSET = 4'd2,
    OP_JCLR = 4'd3,
    OP_CALL = 4'd4,
    OP_RET  = 4'd5
  } seq_op_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic                     pop,
  input  logic [ADDR_W-1:0]        push_addr,
  output logic [ADDR_W-1:0]        top_addr,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] ent [DEPTH];
  logic [LVL_W-1:0]  cnt;

  // entry 0 is the newest; a push shifts older entries down, dropping the last
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[i] <= '0;
      end else if (push) begin
        if (i == 0) ent[i] <= push_addr;
        else        ent[i] <= ent[i-1];
      end else if (pop) begin
        if (i == DEPTH-1) ent[i] <= '0;
        else              ent[i] <= ent[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push) begin
      if (cnt != LVL_W'(DEPTH)) cnt <= cnt + LVL_W'(1);
    end else if (pop) begin
      if (cnt != '0) cnt <= cnt - LVL_W'(1);
    end
  end

  assign top_addr = (cnt == '0) ? '0 : ent[0];
  assign level    = cnt;
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          FLAG_N   = 4,
  parameter logic [11:0] VEC_ADDR = 12'hF00
) (
  input  logic [ADDR_W-1:0]         cur_addr,
  input  logic [OP_W-1:0]           op,
  input  logic [ADDR_W-1:0]         target,
  input  logic [$clog2(FLAG_N)-1:0] flag_sel,
  input  logic [FLAG_N-1:0]         status,
  input  logic                      exc,
  input  logic [ADDR_W-1:0]         ret_addr,
  output logic [ADDR_W-1:0]         nxt_addr,
  output logic                      push,
  output logic                      pop
);
  logic [ADDR_W-1:0] seq_addr;
  logic              flag;

  assign seq_addr = cur_addr + ADDR_W'(1);
  assign flag     = status[flag_sel];

  always_comb begin
    nxt_addr = seq_addr;
    push     = 1'b0;
    pop      = 1'b0;
    if (exc) begin
      nxt_addr = ADDR_W'(VEC_ADDR);
    end else begin
      case (op)
        OP_JMP:  nxt_addr = target;
        OP_JSET: nxt_addr = flag  ? target : seq_addr;
        OP_JCLR: nxt_addr = !flag ? target : seq_addr;
        OP_CALL: begin
          nxt_addr = target;
          push     = 1'b1;
        end
        OP_RET: begin
          nxt_addr = ret_addr;
          pop      = 1'b1;
        end
        default: nxt_addr = seq_addr;
      endcase
    end
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int          P_ADDR_W = useq_pkg::ADDR_W,
  parameter int          P_WORD_W = useq_pkg::WORD_W,
  parameter int          P_CMD_W  = useq_pkg::CMD_W,
  parameter int          P_FLAG_N = useq_pkg::FLAG_N,
  parameter int          P_STK_N  = useq_pkg::STK_N,
  parameter logic [11:0] VEC_ADDR = 12'hF00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] wr_addr_i,
  input  logic [P_WORD_W-1:0] wr_data_i,
  input  logic [P_FLAG_N-1:0] status_i,
  input  logic                exc_i,
  output logic [P_ADDR_W-1:0] addr_o,
  output logic [P_CMD_W-1:0]  cmd_o
);
  localparam int SEL_W = $clog2(P_FLAG_N);
  localparam int LVL_W = $clog2(P_STK_N+1);

  logic [P_ADDR_W-1:0] csar;
  logic [P_ADDR_W-1:0] nxt_addr;
  logic [P_ADDR_W-1:0] rd_addr;
  logic [P_WORD_W-1:0] cur_word;
  logic [P_ADDR_W-1:0] ret_addr;
  logic                do_push, do_pop;
  logic [LVL_W-1:0]    stk_level;

  // the store reads the next address so its registered output tracks csar
  assign rd_addr = rst ? '0 : nxt_addr;

  useq_store #(.ADDR_W(P_ADDR_W), .WORD_W(P_WORD_W)) u_store (
    .clk   (clk),
    .we    (wr_en_i & rst),
    .waddr (wr_addr_i),
    .wdata (wr_data_i),
    .raddr (rd_addr),
    .rdata (cur_word)
  );

  useq_next #(.ADDR_W(P_ADDR_W), .FLAG_N(P_FLAG_N), .VEC_ADDR(VEC_ADDR)) u_next (
    .cur_addr (csar),
    .op       (cur_word[P_WORD_W-P_CMD_W-1 -: OP_W]),
    .target   (cur_word[P_ADDR_W-1:0]),
    .flag_sel (cur_word[P_WORD_W-1 -: SEL_W]),
    .status   (status_i),
    .exc      (exc_i),
    .ret_addr (ret_addr),
    .nxt_addr (nxt_addr),
    .push     (do_push),
    .pop      (do_pop)
  );

  useq_stack #(.ADDR_W(P_ADDR_W), .DEPTH(P_STK_N)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (csar + P_ADDR_W'(1)),
    .top_addr  (ret_addr),
    .level     (stk_level)
  );

  always_ff @(posedge clk) begin
    if (rst) csar <= '0;
    else     csar <= nxt_addr;
  end

  assign addr_o = csar;
  assign cmd_o  = cur_word[P_WORD_W-1 -: P_CMD_W];
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int          ADDR_W   = 12,
  parameter int          WORD_W   = 32,
  parameter int          LVL_W    = 3,
  parameter int          STK_N    = 4,
  parameter logic [11:0] VEC_ADDR = 12'hF00
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [WORD_W-1:0] word,
  input logic [LVL_W-1:0]  level
);
  // R1
  reset_addr_chk: assert property (@(posedge clk) rst |=> addr_o == '0);

  // R8
  exc_vector_chk: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> addr_o == ADDR_W'(VEC_ADDR));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_i && word[15:12] == 4'd0) |=> addr_o == $past(addr_o) + ADDR_W'(1));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_i && word[15:12] == 4'd1) |=> addr_o == $past(word[ADDR_W-1:0]));

  // R7
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(STK_N));

  // R8
  exc_stack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> $stable(level));
endmodule

bind useq_sequencer useq_checker #(
  .ADDR_W(P_ADDR_W), .WORD_W(P_WORD_W), .LVL_W(LVL_W),
  .STK_N(P_STK_N), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .exc_i(exc_i), .addr_o(addr_o),
  .word(cur_word), .level(stk_level)
);

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] VEC = 12'hF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  status = '0;
  logic        exc = 1'b0;
  logic [11:0] addr_o;
  logic [15:0] cmd_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .status_i(status), .exc_i(exc),
    .addr_o(addr_o), .cmd_o(cmd_o)
  );

  function automatic logic [31:0] mk(input logic [15:0] c, input logic [3:0] op,
                                     input logic [11:0] t);
    return {c, op, t};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [31:0] d);
    rst = 1'b1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic start();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1 reset addr", 32'(addr_o), 32'h0);
    put(12'h000, mk(16'h1234, 4'd0, 12'h555));
    put(12'h001, mk(16'h0042, 4'd7, 12'h0AA));
    put(12'h002, mk(16'h0077, 4'd1, 12'h100));
    put(12'h100, mk(16'h2BCD, 4'd0, 12'h000));
    start();
    chk("R1 first fetch addr", 32'(addr_o), 32'h0);
    chk("R2 cmd of word 0", 32'(cmd_o), 32'h1234);
  endtask

  task automatic t_inc_jump();
    tick();
    chk("R3 increment ignores target", 32'(addr_o), 32'h1);
    chk("R2 cmd of word 1", 32'(cmd_o), 32'h0042);
    tick();
    chk("R3 undefined code increments", 32'(addr_o), 32'h2);
    tick();
    chk("R4 absolute jump", 32'(addr_o), 32'h100);
    chk("R4 cmd at target", 32'(cmd_o), 32'h2BCD);
  endtask

  task automatic t_cond();
    // select flag 2 (bits 31:30 = 2), jump if set
    put(12'h000, mk(16'h8000, 4'd2, 12'h020));
    put(12'h020, mk(16'h4000, 4'd3, 12'h030));
    start();
    status = 4'b0100;
    tick();
    chk("R5 jump-if-set taken", 32'(addr_o), 32'h020);
    status = 4'b0000;  // flag 1 clear -> jump-if-clear taken
    tick();
    chk("R5 jump-if-clear taken", 32'(addr_o), 32'h030);
    start();
    status = 4'b1011;  // flag 2 clear
    tick();
    chk("R5 jump-if-set not taken", 32'(addr_o), 32'h001);
    put(12'h000, mk(16'h4000, 4'd3, 12'h020));
    start();
    status = 4'b0010;  // flag 1 set
    tick();
    chk("R5 jump-if-clear not taken", 32'(addr_o), 32'h001);
    status = 4'b0000;
  endtask

  task automatic t_call();
    put(12'h000, mk(16'h0001, 4'd4, 12'h040));
    put(12'h040, mk(16'h0002, 4'd4, 12'h050));
    put(12'h050, mk(16'h0003, 4'd5, 12'h000));
    put(12'h041, mk(16'h0004, 4'd5, 12'h000));
    start();
    tick(); chk("R6 call", 32'(addr_o), 32'h040);
    tick(); chk("R6 nested call", 32'(addr_o), 32'h050);
    tick(); chk("R6 inner return", 32'(addr_o), 32'h041);
    tick(); chk("R6 outer return", 32'(addr_o), 32'h001);
  endtask

  task automatic t_overflow();
    put(12'h000, mk(16'h0, 4'd4, 12'h010));
    put(12'h010, mk(16'h0, 4'd4, 12'h020));
    put(12'h020, mk(16'h0, 4'd4, 12'h030));
    put(12'h030, mk(16'h0, 4'd4, 12'h040));
    put(12'h040, mk(16'h0, 4'd4, 12'h050));
    put(12'h050, mk(16'h0, 4'd5, 12'h000));
    put(12'h041, mk(16'h0, 4'd5, 12'h000));
    put(12'h031, mk(16'h0, 4'd5, 12'h000));
    put(12'h021, mk(16'h0, 4'd5, 12'h000));
    put(12'h011, mk(16'h0, 4'd5, 12'h000));
    start();
    for (int i = 0; i < 5; i++) tick();
    chk("R7 fifth call target", 32'(addr_o), 32'h050);
    tick(); chk("R7 pop 1", 32'(addr_o), 32'h041);
    tick(); chk("R7 pop 2", 32'(addr_o), 32'h031);
    tick(); chk("R7 pop 3", 32'(addr_o), 32'h021);
    tick(); chk("R7 pop 4", 32'(addr_o), 32'h011);
    tick(); chk("R7 oldest dropped, empty pop gives 0", 32'(addr_o), 32'h000);
  endtask

  task automatic t_exc();
    put(12'h000, mk(16'h0, 4'd4, 12'h060));
    put(12'h060, mk(16'h0, 4'd4, 12'h070));
    put(VEC,     mk(16'h3C3C, 4'd5, 12'h000));
    start();
    wr_en = 1'b1; wr_addr = VEC; wr_data = mk(16'hDEAD, 4'd1, 12'h003);
    tick();
    wr_en = 1'b0;
    chk("R6 call before exception", 32'(addr_o), 32'h060);
    exc = 1'b1;
    tick();
    exc = 1'b0;
    chk("R8 exception vector over call", 32'(addr_o), 32'(VEC));
    chk("R9 write while running ignored", 32'(cmd_o), 32'h3C3C);
    tick();
    chk("R8 exception did not push", 32'(addr_o), 32'h001);
    // exception over a plain jump as well
    put(12'h000, mk(16'h0, 4'd1, 12'h123));
    start();
    exc = 1'b1;
    tick();
    exc = 1'b0;
    chk("R8 exception over jump", 32'(addr_o), 32'(VEC));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_inc_jump();
        t_cond();
        t_call();
        t_overflow();
        t_exc();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule